// File: doc/BRIEF.md
# Serial Command and Status Link

This block drives the command side of a bit-serial drive link. When the host presents a 16-bit command word and pulses start, the block sends the word one bit at a time on a single data wire, most significant bit first. An odd-parity bit that it computes itself follows the last data bit. Each bit moves under its own request/acknowledge exchange. The block raises a request while the bit is on the wire, drops the request once the drive acknowledges, and does not present the next bit until the acknowledge has fallen again.

With the command sent, the block turns the link around with the same interlocked exchange. Each raised request now tells the drive that the block can take a bit. The drive places the bit on the status wire and acknowledges, and the block samples it. Seventeen bits come back: a 16-bit status word and its parity bit. The block then checks the parity and pulses done. The acknowledge, status data and command-complete inputs may be asynchronous, and each passes through a synchronizer.

A new command is accepted only while the drive's command-complete input is active. A watchdog limits the time spent waiting on any single handshake edge. If the watchdog expires, the transfer is abandoned and a timeout flag is raised.

Top module: `serial_cmd_link`

## Requirements
- R1: While reset is held and after it, trq_o, cmd_data_o, busy_o, done_o, parity_err_o and timeout_err_o are all 0.
- R2: A start pulse is taken only when the block is idle and the synchronized command-complete input is 1. Otherwise it is ignored: busy_o stays 0 and no request is raised.
- R3: The outgoing frame has 17 bits. The first 16 are the command word, bit 15 first. The 17th makes the count of ones in the frame odd. cmd_data_o holds the current bit for as long as trq_o is 1.
- R4: Each bit uses exactly one handshake. trq_o rises only while the synchronized acknowledge is 0, and it falls after the acknowledge has been seen at 1. A send therefore contains 17 handshakes.
- R5: cmd_data_o does not change while trq_o stays high.
- R6: The reply has 17 bits, and the bit present on csd_i when the acknowledge rises is the one taken. The first 16 bits received form reply_word_o, first received bit in bit 15. This value is valid from the done pulse until the next start.
- R7: parity_err_o is 1 after done exactly when the 17 received bits hold an even number of ones.
- R8: If no expected acknowledge edge arrives within TIMEOUT_CYC clock cycles, the transfer aborts. trq_o drops, done_o pulses, timeout_err_o becomes 1 and reply_word_o reads 0.
- R9: done_o is a one-cycle pulse. busy_o is 1 from the accepted start until the done pulse.
- R10: An accepted start clears parity_err_o and timeout_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a command exchange |
| cmd_word_i | input | 16 | Command word, sampled on an accepted start |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle end-of-exchange pulse |
| reply_word_o | output | 16 | Received status word |
| parity_err_o | output | 1 | Received frame had even parity |
| timeout_err_o | output | 1 | Last exchange aborted by the watchdog |
| cmd_data_o | output | 1 | Serial command bit |
| trq_o | output | 1 | Per-bit transfer request |
| tack_i | input | 1 | Per-bit transfer acknowledge (asynchronous) |
| csd_i | input | 1 | Serial status bit from the drive (asynchronous) |
| cmd_cmpl_i | input | 1 | Drive command-complete indication (asynchronous) |

## Verification
The bench sweeps command and reply words through walking ones, all-zero, all-one and scrambled patterns. Any bit ordering or parity polarity slip shows up either as a wrong captured frame or as a mismatched reply word. Replies with deliberately inverted parity check that the flag is set, and that the next good exchange clears it. A design that latched the flag forever, or never set it, fails one of these two checks. The drive model stalls on a send bit and on a receive bit to catch a watchdog that hangs or leaves the request high. A start issued while command-complete is low checks that a design which ignores that input would begin a transfer it should not.

// File: rtl/cmdlink_pkg.sv
package cmdlink_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TX_REQ = 3'd1,
    ST_TX_REL = 3'd2,
    ST_RX_REQ = 3'd3,
    ST_RX_REL = 3'd4
  } link_state_t;

  // Bit that, appended to v, makes the total count of ones odd.
  function automatic logic odd_fill(input logic [63:0] v);
    return ~(^v);
  endfunction

  // True when a complete frame carries an odd number of ones.
  function automatic logic frame_odd(input logic [63:0] v);
    return ^v;
  endfunction

endpackage

// File: rtl/cmdlink_sync.sv
module cmdlink_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cmdlink_shift.sv
module cmdlink_shift #(
  parameter int FRAME = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [FRAME-1:0] load_val,
  input  logic             shift_en,
  input  logic             shift_in,
  output logic [FRAME-1:0] vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vec <= '0;
    else if (load)     vec <= load_val;
    else if (shift_en) vec <= {vec[FRAME-2:0], shift_in};
  end
endmodule

// File: rtl/cmdlink_watchdog.sv
module cmdlink_watchdog #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!run || kick)           cnt <= '0;
    else if (cnt != CW'(LIMIT - 1))  cnt <= cnt + 1'b1;
  end

  assign expired = run && !kick && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/serial_cmd_link.sv
module serial_cmd_link
  import cmdlink_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] reply_word_o,
  output logic              parity_err_o,
  output logic              timeout_err_o,
  output logic              cmd_data_o,
  output logic              trq_o,
  input  logic              tack_i,
  input  logic              csd_i,
  input  logic              cmd_cmpl_i
);
  localparam int FRAME = WORD_W + 1;
  localparam int CNT_W = $clog2(FRAME + 1);

  link_state_t state, state_nxt;
  logic [CNT_W-1:0] bit_cnt;
  logic [2:0] sync_q;
  logic [FRAME-1:0] frame_q;

  // named internal events
  logic tack_seen, csd_seen, cc_seen;
  logic accept_evt, tx_ack_evt, tx_rel_evt, rx_ack_evt, rx_rel_evt;
  logic last_bit, abort_evt, finish_evt, hs_kick;
  logic shift_en, shift_in;
  logic [FRAME-1:0] load_frame;

  cmdlink_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cmd_cmpl_i, csd_i, tack_i}),
    .q(sync_q)
  );
  assign tack_seen = sync_q[0];
  assign csd_seen  = sync_q[1];
  assign cc_seen   = sync_q[2];

  assign accept_evt = (state == ST_IDLE)   && start_i && cc_seen;
  assign tx_ack_evt = (state == ST_TX_REQ) && tack_seen;
  assign tx_rel_evt = (state == ST_TX_REL) && !tack_seen;
  assign rx_ack_evt = (state == ST_RX_REQ) && tack_seen;
  assign rx_rel_evt = (state == ST_RX_REL) && !tack_seen;
  assign last_bit   = (bit_cnt == CNT_W'(FRAME - 1));
  assign hs_kick    = accept_evt || tx_ack_evt || tx_rel_evt || rx_ack_evt || rx_rel_evt;
  assign finish_evt = rx_rel_evt && last_bit && !abort_evt;

  cmdlink_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_n),
    .run(state != ST_IDLE),
    .kick(hs_kick),
    .expired(abort_evt)
  );

  assign load_frame = {cmd_word_i, odd_fill(64'(cmd_word_i))};
  assign shift_en   = tx_rel_evt || rx_ack_evt;
  assign shift_in   = rx_ack_evt ? csd_seen : 1'b0;

  cmdlink_shift #(.FRAME(FRAME)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(accept_evt),
    .load_val(load_frame),
    .shift_en(shift_en),
    .shift_in(shift_in),
    .vec(frame_q)
  );

  always_comb begin
    state_nxt = state;
    if (abort_evt) state_nxt = ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE:   if (accept_evt) state_nxt = ST_TX_REQ;
        ST_TX_REQ: if (tx_ack_evt) state_nxt = ST_TX_REL;
        ST_TX_REL: if (tx_rel_evt) state_nxt = last_bit ? ST_RX_REQ : ST_TX_REQ;
        ST_RX_REQ: if (rx_ack_evt) state_nxt = ST_RX_REL;
        ST_RX_REL: if (rx_rel_evt) state_nxt = last_bit ? ST_IDLE : ST_RX_REQ;
        default:   state_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
    end else begin
      state <= state_nxt;
      if (accept_evt)
        bit_cnt <= '0;
      else if (tx_rel_evt || rx_rel_evt)
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o        <= 1'b0;
      reply_word_o  <= '0;
      parity_err_o  <= 1'b0;
      timeout_err_o <= 1'b0;
    end else begin
      done_o <= finish_evt || abort_evt;
      if (accept_evt) begin
        parity_err_o  <= 1'b0;
        timeout_err_o <= 1'b0;
        reply_word_o  <= '0;
      end else if (abort_evt) begin
        timeout_err_o <= 1'b1;
        reply_word_o  <= '0;
      end else if (finish_evt) begin
        reply_word_o <= frame_q[FRAME-1:1];
        parity_err_o <= !frame_odd(64'(frame_q));
      end
    end
  end

  assign busy_o     = (state != ST_IDLE);
  assign trq_o      = (state == ST_TX_REQ) || (state == ST_RX_REQ);
  assign cmd_data_o = ((state == ST_TX_REQ) || (state == ST_TX_REL)) ? frame_q[FRAME-1] : 1'b0;

endmodule

// File: rtl/cmdlink_checker.sv
module cmdlink_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic trq,
  input logic cmd_data,
  input logic parity_err,
  input logic timeout_err,
  input logic tack_seen,
  input logic cc_seen,
  input logic accept_evt,
  input logic abort_evt
);
  assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !cc_seen) |=> !busy);

  assert_req_rise_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trq) |-> !tack_seen);

  assert_req_drop_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(trq) && busy) |-> $past(tack_seen));

  assert_data_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trq && $past(trq)) |-> $stable(cmd_data));

  assert_abort_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!trq && done && timeout_err && !busy));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_flags_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (!parity_err && !timeout_err && busy));
endmodule

bind serial_cmd_link cmdlink_checker u_cmdlink_chk (
  .clk(clk), .rst_n(rst_n), .start(start_i), .busy(busy_o), .done(done_o),
  .trq(trq_o), .cmd_data(cmd_data_o), .parity_err(parity_err_o),
  .timeout_err(timeout_err_o), .tack_seen(tack_seen), .cc_seen(cc_seen),
  .accept_evt(accept_evt), .abort_evt(abort_evt)
);

// File: tb/serial_cmd_link_bench.sv
module serial_cmd_link_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        busy, done, parity_err, timeout_err, cmd_data, trq;
  logic [15:0] reply_word;
  logic        tack = 1'b0, csd = 1'b0, cc = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cmd_link #(.WORD_W(16), .SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) u_serial_cmd_link (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_word_i(cmd_word),
    .busy_o(busy), .done_o(done), .reply_word_o(reply_word),
    .parity_err_o(parity_err), .timeout_err_o(timeout_err),
    .cmd_data_o(cmd_data), .trq_o(trq), .tack_i(tack), .csd_i(csd),
    .cmd_cmpl_i(cc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_trq_high;
    while (!trq) @(negedge clk);
  endtask

  task automatic wait_trq_low;
    while (trq) @(negedge clk);
  endtask

  // One full exchange. stall_bit < 0: no stall; 0..16 stall in send; 17..33 stall in receive.
  task automatic exchange(input logic [15:0] cmd, input logic [15:0] rep,
                          input bit bad_par, input int dly, input int stall_bit);
    logic [16:0] got;
    logic [16:0] rframe;
    int hs;
    bit stalled;
    got = '0; hs = 0; stalled = 0;
    rframe = {rep, (~(^rep)) ^ bad_par};
    @(negedge clk);
    cmd_word = cmd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", 32'(busy), 32'd1);
    for (int b = 0; b < 17 && !stalled; b++) begin
      wait_trq_high();
      got = {got[15:0], cmd_data};
      if (stall_bit == b) begin
        stalled = 1;
      end else begin
        idle_cycles(dly);
        chk("R5 data held under request", 32'(cmd_data), 32'(got[0]));
        tack = 1'b1;
        wait_trq_low();
        if (b == 0) cc = 1'b0;
        idle_cycles(dly);
        tack = 1'b0;
        hs++;
      end
    end
    if (!stalled) begin
      chk("R3 command frame", 32'(got), 32'({cmd, ~(^cmd)}));
      chk("R4 send handshakes", 32'(hs), 32'd17);
      for (int b = 0; b < 17 && !stalled; b++) begin
        wait_trq_high();
        if (stall_bit == 17 + b) begin
          stalled = 1;
        end else begin
          csd = rframe[16-b];
          @(negedge clk);
          idle_cycles(dly);
          tack = 1'b1;
          wait_trq_low();
          idle_cycles(dly);
          tack = 1'b0;
        end
      end
    end
    while (!done) @(negedge clk);
    if (stalled) begin
      chk("R8 timeout flag", 32'(timeout_err), 32'd1);
      chk("R8 request dropped", 32'(trq), 32'd0);
      chk("R8 reply cleared", 32'(reply_word), 32'd0);
    end else begin
      chk("R6 reply word", 32'(reply_word), 32'(rep));
      chk("R7 parity flag", 32'(parity_err), 32'(bad_par));
      chk("R10 timeout flag clear", 32'(timeout_err), 32'd0);
    end
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 32'd0);
    chk("R9 busy low after done", 32'(busy), 32'd0);
    tack = 1'b0;
    cc = 1'b1;
    idle_cycles(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle_cycles(3);
    chk("R1 reset trq", 32'(trq), 32'd0);
    chk("R1 reset outputs", 32'({busy, done, parity_err, timeout_err, cmd_data}), 32'd0);
    rst_n = 1'b1;
    idle_cycles(4);
    chk("R1 idle after reset", 32'({trq, busy, done, parity_err, timeout_err}), 32'd0);

    // R2: start refused while command-complete is low
    cc = 1'b0;
    idle_cycles(4);
    @(negedge clk); start = 1'b1; cmd_word = 16'h1234;
    @(negedge clk); start = 1'b0;
    idle_cycles(6);
    chk("R2 start ignored busy", 32'(busy), 32'd0);
    chk("R2 start ignored trq", 32'(trq), 32'd0);
    cc = 1'b1;
    idle_cycles(4);

    for (int i = 0; i < 40; i++) begin
      logic [15:0] c, r;
      if (i < 16)       c = 16'h0001 << i;
      else if (i == 16) c = 16'h0000;
      else if (i == 17) c = 16'hFFFF;
      else              c = 16'(i * 16'h2F1B) ^ 16'hA5C3;
      r = ~c ^ 16'(i * 16'h0137);
      exchange(c, r, (i % 5) == 3, i % 4, -1);
    end

    // R10: flags cleared by a good exchange after a parity failure
    exchange(16'hBEEF, 16'h0F0F, 1'b1, 1, -1);
    exchange(16'h5A5A, 16'h8001, 1'b0, 0, -1);

    // R8: stall in send phase and in receive phase
    exchange(16'hC3C3, 16'h1111, 1'b0, 1, 5);
    exchange(16'h7E81, 16'h2222, 1'b0, 1, 17 + 9);
    exchange(16'h0F0F, 16'h3C3C, 1'b0, 2, -1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule